// File: doc/BRIEF.md
# Converter Power and Clock-Mode Controller

This controller decides, cycle by cycle, whether a successive-approximation converter is running, resting in one of two software low-power states, or held off by the hardware shutdown input. It also records which clock paces the conversion, internal or the serial clock, and drives the busy strobe that a host watches in internal-clock mode. A serial front end feeds it with a start-bit event and with the two power/clock bits of each accepted control byte. The conversion engine returns a done pulse.

A software power-down request is held back until the running conversion finishes, and that conversion keeps the clock mode that was last chosen. A hardware shutdown stops the conversion in the same cycle and raises a one-cycle abort pulse. After power-on reset the block counts off a settling interval, given in microseconds and converted to system-clock cycles. Until that interval ends it refuses conversions. It also flags that the output should shift zeros until the first conversion finishes. Whether the internal oscillator runs at its fast or slow rate is only passed through as status.

Top module: `conv_power_ctrl`

## Requirements
- R1: Reset gives pwr_state=0 (running), clk_ext=0 (internal clock), strobe=1, conv_busy=0, conv_abort=0, zero_fill=1 and ready=0. ready rises on exactly the RST_CYCLES-th rising clock edge after rst_n is released, where RST_CYCLES = (CLK_HZ/1000)*RST_US/1000, which is 500 by default.
- R2: A control byte is accepted only when cmd_valid=1, cs_n=0, shdn_n=1 and ready=1. Any other control byte leaves every output unchanged, and so does a start event while cs_n=1.
- R3: An accepted byte with cmd_pd[1]=1 starts a conversion (conv_busy=1 after the edge). It sets clk_ext=cmd_pd[0], so 10 selects the internal clock and 11 the external clock. pwr_state stays 0 after the conversion completes.
- R4: An accepted byte with cmd_pd[1]=0 starts a conversion and leaves clk_ext unchanged. pwr_state stays 0 while conv_busy=1. On conv_done it becomes 2 (full power-down) for 00 or 1 (fast power-down) for 01.
- R5: A start event while cs_n=0 and shdn_n=1 returns pwr_state to 0 from either software power-down state.
- R6: With shdn_n=0, pwr_state becomes 3 and conv_busy clears after the next edge. conv_abort pulses high for that one cycle only if a conversion was running, and any deferred power-down is discarded. When shdn_n returns high, pwr_state becomes 0.
- R7: With clk_ext=0, strobe is the inverse of conv_busy. With clk_ext=1, strobe is 0. cs_n never affects strobe.
- R8: cs_n=1 does not end a running conversion. conv_done still completes it.
- R9: zero_fill stays 1 until the first conv_done that ends a conversion, and is 0 from then until reset.
- R10: osc_fast follows shdn_float at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| shdn_n | input | 1 | Hardware shutdown, low = off |
| shdn_float | input | 1 | Shutdown pin left floating (fast oscillator) |
| cs_n | input | 1 | Chip select, low = selected |
| start_evt | input | 1 | Start bit detected (pulse) |
| cmd_valid | input | 1 | Control byte complete (pulse) |
| cmd_pd | input | 2 | Power/clock bits of the control byte |
| conv_done | input | 1 | Conversion finished (pulse) |
| pwr_state | output | 2 | 0 run, 1 fast power-down, 2 full power-down, 3 hardware off |
| clk_ext | output | 1 | 1 = external serial clock paces conversion |
| conv_busy | output | 1 | Conversion in progress |
| conv_abort | output | 1 | One-cycle pulse: conversion killed by shutdown |
| strobe | output | 1 | Busy strobe, low while converting in internal mode |
| ready | output | 1 | Reset settling interval elapsed |
| zero_fill | output | 1 | No result yet, shift zeros |
| osc_fast | output | 1 | Internal oscillator fast-rate status |

## Verification
The bench targets a power-down byte issued while in external-clock mode. A design that wrongly copied the low bit into the clock mode would show clk_ext falling during the deferred conversion. It also raises chip select in the middle of a conversion and issues a byte then, which a design wrongly tied to select would answer by dropping busy or starting anew. Hardware shutdown is applied both with and without a running conversion, so an abort pulse in the idle case, or a lost power-down that survives the shutdown, shows as a mismatch. The settling count is checked at the single edge where ready must rise, catching off-by-one counters.

// File: rtl/conv_power_ctrl.sv
module conv_power_ctrl #(
  parameter int CLK_HZ = 50_000_000,
  parameter int RST_US = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_n,
  input  logic       shdn_float,
  input  logic       cs_n,
  input  logic       start_evt,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_pd,
  input  logic       conv_done,
  output logic [1:0] pwr_state,
  output logic       clk_ext,
  output logic       conv_busy,
  output logic       conv_abort,
  output logic       strobe,
  output logic       ready,
  output logic       zero_fill,
  output logic       osc_fast
);
  localparam int RST_CYCLES = (CLK_HZ / 1000) * RST_US / 1000;
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [1:0] P_RUN = 2'd0, P_FAST = 2'd1, P_FULL = 2'd2, P_HW = 2'd3;

  logic [CW-1:0] cnt;
  logic          pend_v, pend_full;
  logic          accept, wake;

  assign accept   = !cs_n && cmd_valid && ready;
  assign wake     = (pwr_state == P_HW) || (!cs_n && start_evt);
  assign strobe   = clk_ext ? 1'b0 : !conv_busy;
  assign osc_fast = shdn_float;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      ready      <= 1'b0;
      pwr_state  <= P_RUN;
      clk_ext    <= 1'b0;
      conv_busy  <= 1'b0;
      conv_abort <= 1'b0;
      zero_fill  <= 1'b1;
      pend_v     <= 1'b0;
      pend_full  <= 1'b0;
    end else begin
      conv_abort <= 1'b0;
      if (!ready) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(RST_CYCLES - 1)) ready <= 1'b1;
      end
      if (shdn_n && conv_busy && conv_done) zero_fill <= 1'b0;
      if (!shdn_n) begin
        pwr_state  <= P_HW;
        conv_busy  <= 1'b0;
        pend_v     <= 1'b0;
        conv_abort <= conv_busy;
      end else if (accept) begin
        pwr_state <= P_RUN;
        conv_busy <= 1'b1;
        if (cmd_pd[1]) begin
          clk_ext <= cmd_pd[0];
          pend_v  <= 1'b0;
        end else begin
          pend_v    <= 1'b1;
          pend_full <= !cmd_pd[0];
        end
      end else if (conv_busy && conv_done) begin
        conv_busy <= 1'b0;
        pend_v    <= 1'b0;
        pwr_state <= pend_v ? (pend_full ? P_FULL : P_FAST) : P_RUN;
      end else if (wake) begin
        pwr_state <= P_RUN;
      end
    end
  end

  // R1
  no_conv_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !conv_busy);
  // R4
  run_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> pwr_state == P_RUN);
  // R6
  abort_lands_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> (pwr_state == P_HW) && !conv_busy);
  // R8
  cs_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && cs_n && shdn_n && !conv_done) |=> conv_busy);
  // R9
  zero_fill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_fill |=> !zero_fill);
  // R3
  keep_run_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && shdn_n && conv_done && !pend_v && !(cmd_valid && !cs_n)) |=> pwr_state == P_RUN);
endmodule

// File: tb/test_conv_power_ctrl.sv
`timescale 1ns/1ps
module test_conv_power_ctrl;
  localparam int RST = 500;
  logic clk = 0, rst_n = 0, shdn_n = 1, shdn_float = 0, cs_n = 1;
  logic start_evt = 0, cmd_valid = 0, conv_done = 0;
  logic [1:0] cmd_pd = 0;
  logic [1:0] pwr_state;
  logic clk_ext, conv_busy, conv_abort, strobe, ready, zero_fill, osc_fast;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  conv_power_ctrl i_conv_power_ctrl (.*);

  always #10 clk = ~clk;

  int m_pwr = 0, m_ext = 0, m_busy = 0, m_blank = 1, m_ready = 0, m_abort = 0, m_pend = 0, m_cnt = 0;

  always @(posedge clk) begin
    int r0;
    if (!rst_n) begin
      m_pwr = 0; m_ext = 0; m_busy = 0; m_blank = 1; m_ready = 0; m_abort = 0; m_pend = 0; m_cnt = 0;
    end else begin
      r0 = m_ready;
      if (!m_ready) begin m_cnt++; if (m_cnt == RST) m_ready = 1; end
      m_abort = 0;
      if (!shdn_n) begin
        m_abort = m_busy; m_busy = 0; m_pend = 0; m_pwr = 3;
      end else begin
        if (m_pwr == 3) m_pwr = 0;
        if (!cs_n && start_evt) m_pwr = 0;
        if (m_busy && conv_done) begin
          m_busy = 0; m_blank = 0;
          if (m_pend != 0) m_pwr = m_pend;
          m_pend = 0;
        end
        if (!cs_n && cmd_valid && r0 == 1) begin
          m_pwr = 0; m_busy = 1;
          if (cmd_pd[1]) begin m_ext = cmd_pd[0]; m_pend = 0; end
          else m_pend = cmd_pd[0] ? 1 : 2;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R1/R4/R5/R6 pwr_state", int'(pwr_state), m_pwr);
    chk("R3 clk_ext", int'(clk_ext), m_ext);
    chk("R2/R8 conv_busy", int'(conv_busy), m_busy);
    chk("R6 conv_abort", int'(conv_abort), m_abort);
    chk("R7 strobe", int'(strobe), m_ext ? 0 : (m_busy ? 0 : 1));
    chk("R1 ready", int'(ready), m_ready);
    chk("R9 zero_fill", int'(zero_fill), m_blank);
    chk("R10 osc_fast", int'(osc_fast), int'(shdn_float));
  end

  task automatic send_cmd(input logic [1:0] pd);
    cmd_pd = pd; cmd_valid = 1; @(negedge clk); cmd_valid = 0;
  endtask
  task automatic pulse_done();
    conv_done = 1; @(negedge clk); conv_done = 0;
  endtask
  task automatic pulse_start();
    start_evt = 1; @(negedge clk); start_evt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pwr", int'(pwr_state), 0);
    chk("R1 reset strobe", int'(strobe), 1);
    chk("R1 reset zero_fill", int'(zero_fill), 1);
    chk("R1 reset ready", int'(ready), 0);
    rst_n = 1;
    for (int i = 1; i < RST; i++) begin
      @(negedge clk);
      if (i == 10) begin cs_n = 0; cmd_pd = 2'b11; cmd_valid = 1; end
      if (i == 11) cmd_valid = 0;
      if (i == 12) chk("R2 cmd before ready", int'(conv_busy), 0);
    end
    chk("R1 ready one edge early", int'(ready), 0);
    @(negedge clk);
    chk("R1 ready at count", int'(ready), 1);
    send_cmd(2'b10);
    chk("R3 internal busy", int'(conv_busy), 1);
    chk("R7 strobe low internal", int'(strobe), 0);
    repeat (3) @(negedge clk);
    pulse_done();
    chk("R9 zero_fill cleared", int'(zero_fill), 0);
    chk("R3 stays running", int'(pwr_state), 0);
    send_cmd(2'b11);
    chk("R3 external mode", int'(clk_ext), 1);
    chk("R7 strobe low external", int'(strobe), 0);
    pulse_done();
    send_cmd(2'b00);
    chk("R4 clock kept", int'(clk_ext), 1);
    chk("R4 running while busy", int'(pwr_state), 0);
    pulse_done();
    chk("R4 full power-down", int'(pwr_state), 2);
    cs_n = 1; pulse_start();
    chk("R2 start ignored cs high", int'(pwr_state), 2);
    cs_n = 0; pulse_start();
    chk("R5 wake from full", int'(pwr_state), 0);
    send_cmd(2'b10);
    send_cmd(2'b01);
    chk("R4 internal kept", int'(clk_ext), 0);
    cs_n = 1;
    repeat (5) @(negedge clk);
    send_cmd(2'b11);
    chk("R8 busy with cs high", int'(conv_busy), 1);
    chk("R2 cmd ignored cs high", int'(clk_ext), 0);
    pulse_done();
    chk("R4 fast power-down", int'(pwr_state), 1);
    cs_n = 0; pulse_start();
    chk("R5 wake from fast", int'(pwr_state), 0);
    send_cmd(2'b00);
    shdn_n = 0; @(negedge clk);
    chk("R6 abort pulse", int'(conv_abort), 1);
    chk("R6 hw off", int'(pwr_state), 3);
    @(negedge clk);
    chk("R6 abort one cycle", int'(conv_abort), 0);
    send_cmd(2'b10);
    chk("R2 cmd ignored in shutdown", int'(conv_busy), 0);
    shdn_n = 1; @(negedge clk);
    chk("R6 release to run", int'(pwr_state), 0);
    pulse_done();
    chk("R6 pending dropped", int'(pwr_state), 0);
    shdn_n = 0; @(negedge clk);
    chk("R6 no abort when idle", int'(conv_abort), 0);
    shdn_n = 1;
    shdn_float = 1; @(negedge clk);
    chk("R10 osc fast", int'(osc_fast), 1);
    shdn_float = 0; @(negedge clk);
    chk("R10 osc slow", int'(osc_fast), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule